// File: doc/BRIEF.md
# Nibble-Stream Elastic Buffer

This block passes a nibble-wide frame stream, with MII-style data, data-valid and error lines, from one clock-enable domain into another. Both domains run on the same system clock, and each side has its own enable strobe. The receive side writes one stage on each receive enable. The transmit side reads one stage on each transmit enable. The two enable streams may run at slightly different average rates.

The storage is a small shift-register FIFO built from flip-flops. At the start of each frame the output does not begin until a set number of nibbles is held. That reserve lets the transmit side run a few enable periods faster or slower than the receive side over a long frame without running dry or spilling. The end of each received frame is kept in the buffer as a marker entry. When the marker reaches the output, the output frame closes and the start-of-frame wait arms again. Underflow and overflow are detected and reported on the output error line for the rest of the frame.

Top module: `mii_elastic_buffer`

## Requirements
- R1: A synchronous reset `rst` empties every stage. On the cycle after a reset edge, `txEn`, `txEr` and `txData` are all 0. After reset, no nibble from before the reset ever reaches the output.
- R2: `txEn`, `txEr` and `txData` change only on clock edges where `txCe` is 1. Otherwise they hold their value.
- R3: Between frames, `txEn` rises on a `txCe` edge only if, before that edge, the buffer already holds at least `WATERMARK` entries or holds a complete frame including its end marker. An empty buffer never starts output.
- R4: Once a frame has started, every `txCe` edge emits the next stored nibble in arrival order, with `txEn`=1 and `txData` equal to the received nibble. `txEr` repeats the `rxEr` value that came with that nibble.
- R5: A `rxCe` edge with `rxDv`=0 that follows a data nibble stores an end marker. When the marker is read, `txEn`, `txEr` and `txData` go to 0, and the next frame again waits as in R3.
- R6: A frame shorter than `WATERMARK` nibbles is still sent in full, without error, once its end marker is stored.
- R7: If a `txCe` edge finds the buffer empty during a frame (underflow), the output gives `txEn`=1, `txEr`=1, `txData`=0. `txEr` then stays 1 on every nibble until that frame's end marker is read.
- R8: If a data nibble arrives while all stages are full and nothing is read on that edge (overflow), the nibble is dropped and `txEr` is 1 on every later output nibble of the frame. An end marker that arrives while the buffer is full replaces the newest entry, so the frame still closes.
- R9: Frames that follow each other with a single idle receive slot between them come out as separate `txEn` bursts, with their nibbles intact.
- R10: With `DEPTH`=16 and `WATERMARK`=8, a 4000-nibble frame passes through unchanged and without error when the transmit enable runs 5 periods slower, or 5 periods faster, than the receive enable over the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock shared by both enable domains |
| rst | input | 1 | Synchronous reset, active high |
| rxCe | input | 1 | Receive-side clock enable |
| rxData | input | 4 | Received nibble |
| rxDv | input | 1 | Received nibble is part of a frame |
| rxEr | input | 1 | Received nibble carries an error |
| txCe | input | 1 | Transmit-side clock enable |
| txData | output | 4 | Transmitted nibble, 0 outside frames |
| txEn | output | 1 | Transmitted nibble is part of a frame |
| txEr | output | 1 | Transmitted nibble carries an error |

## Verification
The main path is tried under four kinds of rate pattern:
- **Equal rates.** Any loss, duplication or misplaced error bit shows up directly.
- **Transmit at twice the receive rate.** This exposes the exact fill count at which output starts, and then forces underflow.
- **Receive at three times the transmit rate.** This forces overflow and the replacement of the newest entry by the end marker.
- **Long frames with a drifting transmit rate.** These show whether the watermark reserve covers slip in both directions.

Short frames, back-to-back frames and a reset in mid-frame separate the end-marker start rule, frame separation and the clearing of storage from the plain streaming case.

// File: rtl/mii_elastic_pkg.sv
package mii_elastic_pkg;

  localparam int NIBBLE_W = 4;

  // One storage stage. An occupied stage with dv=0 marks the end of a frame.
  typedef struct packed {
    logic                used;
    logic                dv;
    logic                er;
    logic [NIBBLE_W-1:0] data;
  } meb_stage_t;

  // Strobes from the control to the storage.
  typedef struct packed {
    logic       push;     // write wrStage behind the newest entry
    logic       pop;      // shift every stage one step toward the head
    logic       tailEnd;  // buffer full: replace the newest entry by wrStage
    meb_stage_t wrStage;
  } meb_strobe_t;

  typedef enum logic {
    TX_WAIT = 1'b0,
    TX_SEND = 1'b1
  } meb_tx_state_t;

endpackage

// File: rtl/meb_store.sv
module meb_store
  import mii_elastic_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int FILL_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  meb_strobe_t       strobes,
  output meb_stage_t        headStage,
  output logic [FILL_W-1:0] fill,
  output logic              full,
  output logic              endPresent
);

  meb_stage_t        stages [DEPTH];
  logic [FILL_W-1:0] wrIdx;
  logic [DEPTH-1:0]  usedVec;
  logic [DEPTH-1:0]  endVec;

  // After a pop, the free slot behind the newest entry moves one step down.
  assign wrIdx = fill - FILL_W'(strobes.pop);

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    localparam bit IS_TAIL = (i == DEPTH - 1);
    meb_stage_t shifted;
    meb_stage_t nxt;

    if (IS_TAIL) begin : g_last
      assign shifted = strobes.pop ? '0 : stages[i];
    end else begin : g_mid
      assign shifted = strobes.pop ? stages[i+1] : stages[i];
    end

    always_comb begin
      nxt = shifted;
      if (strobes.push && (wrIdx == FILL_W'(i))) begin
        nxt = strobes.wrStage;
      end
      if (IS_TAIL && strobes.tailEnd) begin
        nxt = strobes.wrStage;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        stages[i] <= '0;
      end else begin
        stages[i] <= nxt;
      end
    end

    assign usedVec[i] = stages[i].used;
    assign endVec[i]  = stages[i].used & ~stages[i].dv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill <= '0;
    end else begin
      fill <= fill + FILL_W'(strobes.push) - FILL_W'(strobes.pop);
    end
  end

  assign headStage  = stages[0];
  assign full       = (fill == FILL_W'(DEPTH));
  assign endPresent = |endVec;

  // The occupied flags and the fill counter must agree (R4 ordering relies on it).
  assert_fill_match_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(usedVec) == int'(fill));

  // Never shift out of an empty buffer (R7).
  assert_no_pop_empty_R7: assert property (@(posedge clk) disable iff (rst)
    strobes.pop |-> usedVec[0]);

  // A push that is not balanced by a pop needs a free stage (R8).
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (strobes.push && !strobes.pop) |-> !full);

  // Replacing the newest entry happens only on a full, otherwise idle buffer (R8).
  assert_tail_replace_R8: assert property (@(posedge clk) disable iff (rst)
    strobes.tailEnd |-> (full && !strobes.pop && !strobes.push));

endmodule

// File: rtl/meb_ctrl.sv
module meb_ctrl
  import mii_elastic_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int WATERMARK = 8,
  parameter int FILL_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rxCe,
  input  logic [NIBBLE_W-1:0] rxData,
  input  logic                rxDv,
  input  logic                rxEr,
  input  logic                txCe,
  input  meb_stage_t          headStage,
  input  logic [FILL_W-1:0]   fill,
  input  logic                full,
  input  logic                endPresent,
  output meb_strobe_t         strobes,
  output logic [NIBBLE_W-1:0] txData,
  output logic                txEn,
  output logic                txEr
);

  meb_tx_state_t txState;
  logic          rxInFrame;
  logic          errSticky;
  logic          rxWantData;
  logic          rxWantEnd;
  logic          startOk;
  logic          txAct;
  logic          popNow;
  logic          roomLost;
  logic          overflowNow;

  // Receive side: a data nibble, or the end marker after a frame.
  assign rxWantData = rxCe && rxDv;
  assign rxWantEnd  = rxCe && !rxDv && rxInFrame;

  always_ff @(posedge clk) begin
    if (rst) begin
      rxInFrame <= 1'b0;
    end else if (rxCe) begin
      rxInFrame <= rxDv;
    end
  end

  // Transmit side: begin a frame only with enough reserve, or a whole frame, stored.
  assign startOk = (fill >= FILL_W'(WATERMARK)) || endPresent;
  assign txAct   = txCe && ((txState == TX_SEND) || startOk);
  assign popNow  = txAct && headStage.used;

  assign roomLost    = full && !popNow;
  assign overflowNow = rxWantData && roomLost;

  always_comb begin
    strobes.pop             = popNow;
    strobes.push            = (rxWantData || rxWantEnd) && !roomLost;
    strobes.tailEnd         = rxWantEnd && roomLost;
    strobes.wrStage.used    = 1'b1;
    strobes.wrStage.dv      = rxWantData;
    strobes.wrStage.er      = rxWantData && rxEr;
    strobes.wrStage.data    = rxWantData ? rxData : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txState   <= TX_WAIT;
      errSticky <= 1'b0;
      txEn      <= 1'b0;
      txEr      <= 1'b0;
      txData    <= '0;
    end else begin
      if (txAct) begin
        if (!headStage.used) begin
          // underflow inside a frame
          txEn      <= 1'b1;
          txEr      <= 1'b1;
          txData    <= '0;
          errSticky <= 1'b1;
        end else if (headStage.dv) begin
          txEn    <= 1'b1;
          txEr    <= headStage.er || errSticky;
          txData  <= headStage.data;
          txState <= TX_SEND;
        end else begin
          // end marker closes the frame and re-arms the watermark wait
          txEn      <= 1'b0;
          txEr      <= 1'b0;
          txData    <= '0;
          txState   <= TX_WAIT;
          errSticky <= 1'b0;
        end
      end else if (txCe) begin
        txEn   <= 1'b0;
        txEr   <= 1'b0;
        txData <= '0;
      end
      if (overflowNow) begin
        errSticky <= 1'b1;
      end
    end
  end

  // Outputs are cleared by reset (R1).
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!txEn && !txEr && txData == '0));

  // Outputs move only on transmit enables (R2).
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !txCe |=> $stable({txEn, txEr, txData}));

  // A frame starts only with the reserve or a complete frame stored (R3).
  assert_start_gate_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(txEn) |-> (($past(fill) >= FILL_W'(WATERMARK)) || $past(endPresent)));

  // An empty buffer in mid-frame yields an errored nibble (R7).
  assert_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    (txState == TX_SEND && txCe && fill == '0) |=> (txEn && txEr));

  // A dropped nibble leaves the buffer full (R8).
  assert_overflow_full_R8: assert property (@(posedge clk) disable iff (rst)
    overflowNow |=> full);

endmodule

// File: rtl/mii_elastic_buffer.sv
module mii_elastic_buffer
  import mii_elastic_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int WATERMARK = 8   // must be at least 1 and below DEPTH
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxCe,
  input  logic [3:0] rxData,
  input  logic       rxDv,
  input  logic       rxEr,
  input  logic       txCe,
  output logic [3:0] txData,
  output logic       txEn,
  output logic       txEr
);

  localparam int FILL_W = $clog2(DEPTH + 1);

  meb_strobe_t       strobes;
  meb_stage_t        headStage;
  logic [FILL_W-1:0] fill;
  logic              full;
  logic              endPresent;

  meb_ctrl #(
    .DEPTH    (DEPTH),
    .WATERMARK(WATERMARK),
    .FILL_W   (FILL_W)
  ) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .rxCe      (rxCe),
    .rxData    (rxData),
    .rxDv      (rxDv),
    .rxEr      (rxEr),
    .txCe      (txCe),
    .headStage (headStage),
    .fill      (fill),
    .full      (full),
    .endPresent(endPresent),
    .strobes   (strobes),
    .txData    (txData),
    .txEn      (txEn),
    .txEr      (txEr)
  );

  meb_store #(
    .DEPTH (DEPTH),
    .FILL_W(FILL_W)
  ) i_store (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .headStage (headStage),
    .fill      (fill),
    .full      (full),
    .endPresent(endPresent)
  );

endmodule

// File: tb/test_mii_elastic_buffer.sv
module test_mii_elastic_buffer;

  localparam int DEPTH = 16;
  localparam int WM    = 8;
  localparam int MAXN  = 8192;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxCe = 1'b0;
  logic       rxDv = 1'b0;
  logic       rxEr = 1'b0;
  logic [3:0] rxData = 4'd0;
  logic       txCe = 1'b0;
  logic [3:0] txData;
  logic       txEn;
  logic       txEr;

  always #4 clk = ~clk;

  mii_elastic_buffer #(.DEPTH(DEPTH), .WATERMARK(WM)) i_mii_elastic_buffer (
    .clk(clk), .rst(rst), .rxCe(rxCe), .rxData(rxData), .rxDv(rxDv), .rxEr(rxEr),
    .txCe(txCe), .txData(txData), .txEn(txEn), .txEr(txEr)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [5:0] tape [MAXN];
  int         tapeLen = 0, tapePos = 0;
  logic [3:0] expData [MAXN];
  logic       expErr [MAXN];
  int         expLen = 0;
  logic [3:0] outData [MAXN];
  logic       outErr [MAXN];
  int         outCnt = 0, bursts = 0, startBefore = -1;

  int  rxPer = 1, txPer = 1, stretchEvery = 0, stretchDelta = 0;
  bit  genOn = 1'b0;
  int  rxCnt = 0, txCnt = 0, txSlots = 0, dvConsumed = 0, holdViol = 0;
  bit  lastDv = 1'b0, txCeQ = 1'b0, prevEn = 1'b0;
  logic [5:0] prevOut = 6'd0;

  // Monitor, then drive: all at the falling edge.
  always @(negedge clk) begin
    int lim;
    if (!rst && !txCeQ && ({txEn, txEr, txData} != prevOut)) holdViol++;
    if (txCeQ && !rst && txEn) begin
      if (!prevEn) begin
        bursts++;
        if (startBefore < 0) startBefore = dvConsumed - int'(lastDv);
      end
      if (outCnt < MAXN) begin
        outData[outCnt] = txData;
        outErr[outCnt]  = txEr;
      end
      outCnt++;
    end
    prevEn  = txEn;
    prevOut = {txEn, txEr, txData};

    lastDv = 1'b0;
    if (genOn) begin
      rxCe  = (rxCnt == 0);
      rxCnt = (rxCnt + 1 >= rxPer) ? 0 : rxCnt + 1;
      if (rxCe && tapePos < tapeLen) begin
        {rxDv, rxEr, rxData} = tape[tapePos];
        tapePos++;
        lastDv = rxDv;
        if (rxDv) dvConsumed++;
      end else begin
        {rxDv, rxEr, rxData} = 6'd0;
      end
      txCe = (txCnt == 0);
      lim  = txPer + ((stretchEvery > 0 && (txSlots % stretchEvery) == stretchEvery - 1)
                      ? stretchDelta : 0);
      txCnt++;
      if (txCnt >= lim) begin
        txCnt = 0;
        txSlots++;
      end
    end else begin
      rxCe = 1'b0;
      txCe = 1'b0;
    end
    txCeQ = txCe;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic setup(input int rp, input int tp, input int se, input int sd);
    rxPer = rp; txPer = tp; stretchEvery = se; stretchDelta = sd;
    rxCnt = 0; txCnt = 0; txSlots = 0; dvConsumed = 0;
    tapeLen = 0; tapePos = 0; expLen = 0;
    outCnt = 0; bursts = 0; startBefore = -1;
    genOn = 1'b1;
  endtask

  task automatic addFrame(input int len, input int seed, input int errAt);
    for (int i = 0; i < len; i++) begin
      logic [3:0] d;
      logic       e;
      d = 4'((i * 5 + seed + (i >> 4)) & 15);
      e = (i == errAt);
      tape[tapeLen] = {1'b1, e, d};
      tapeLen++;
      expData[expLen] = d;
      expErr[expLen]  = e;
      expLen++;
    end
    tape[tapeLen] = 6'd0;
    tapeLen++;
  endtask

  task automatic compareAll(input string tag);
    int mism = 0;
    check(outCnt == expLen, {tag, " nibble count"}, outCnt, expLen);
    for (int j = 0; j < expLen && j < outCnt; j++) begin
      if (outData[j] != expData[j] || outErr[j] != expErr[j]) mism++;
    end
    check(mism == 0, {tag, " nibble mismatches"}, mism, 0);
  endtask

  task automatic checkSticky(input string tag);
    int first = -1;
    int viol  = 0;
    for (int j = 0; j < outCnt && j < MAXN; j++) begin
      if (first < 0 && outErr[j]) first = j;
      if (first >= 0 && !outErr[j]) viol++;
    end
    check(first >= 0, {tag, " error raised"}, first, 0);
    check(viol == 0, {tag, " error held to frame end"}, viol, 0);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    // R1: reset state
    check({txEn, txEr, txData} == 6'd0, "R1 outputs after reset", int'({txEn, txEr, txData}), 0);

    // R3: enables running, nothing stored, no start
    setup(1, 1, 0, 0);
    step(20);
    check(bursts == 0 && txEn == 1'b0, "R3 empty buffer never starts", bursts, 0);

    // R3, R7: transmit twice as fast as receive
    setup(2, 1, 0, 0);
    addFrame(30, 3, -1);
    step(30 * 2 + 100);
    check(startBefore == WM, "R3 start fill level", startBefore, WM);
    check(outErr[0] == 1'b0, "R7 first nibble clean", int'(outErr[0]), 0);
    checkSticky("R7 underflow");
    check(bursts == 1 && txEn == 1'b0, "R5 frame closes", bursts, 1);

    // R5: watermark wait re-arms for the next frame
    setup(2, 1, 0, 0);
    addFrame(30, 9, -1);
    step(30 * 2 + 100);
    check(startBefore == WM, "R5 re-armed start level", startBefore, WM);
    check(outErr[0] == 1'b0, "R5 error cleared for new frame", int'(outErr[0]), 0);

    // R6: frame shorter than the watermark
    setup(2, 1, 0, 0);
    addFrame(3, 1, -1);
    step(60);
    compareAll("R6 short frame");

    // R4: equal rates with one errored nibble
    setup(1, 1, 0, 0);
    addFrame(20, 5, 11);
    step(80);
    compareAll("R4 order and error position");
    check(bursts == 1 && txEn == 1'b0, "R5 end after errored frame", bursts, 1);

    // R9: back-to-back frames
    setup(2, 2, 0, 0);
    addFrame(12, 2, -1);
    addFrame(10, 7, -1);
    step(24 * 2 + 120);
    check(bursts == 2, "R9 separate bursts", bursts, 2);
    compareAll("R9 both frames intact");

    // R8: receive three times as fast as transmit
    setup(1, 3, 0, 0);
    addFrame(40, 4, -1);
    step(400);
    check(outCnt < expLen, "R8 nibbles dropped", outCnt, expLen);
    checkSticky("R8 overflow");
    check(bursts == 1 && txEn == 1'b0, "R8 frame still closes", bursts, 1);

    // R1: reset in mid-frame, then a clean frame with no leftovers
    setup(2, 2, 0, 0);
    addFrame(30, 6, -1);
    step(30);
    rst = 1'b1;
    tapePos = tapeLen;
    step(2);
    rst = 1'b0;
    check({txEn, txEr, txData} == 6'd0, "R1 outputs after mid-frame reset",
          int'({txEn, txEr, txData}), 0);
    setup(2, 2, 0, 0);
    addFrame(16, 8, -1);
    step(16 * 2 + 100);
    compareAll("R1 storage cleared");

    // R10: long frame, transmit slower by 5 periods
    setup(4, 4, 800, 1);
    addFrame(4000, 11, -1);
    step(4002 * 4 + 400);
    compareAll("R10 slow transmit");

    // R10: long frame, transmit faster by 5 periods
    setup(4, 4, 800, -1);
    addFrame(4000, 13, -1);
    step(4002 * 4 + 400);
    compareAll("R10 fast transmit");

    // R2: outputs never moved without a transmit enable
    check(holdViol == 0, "R2 outputs held between enables", holdViol, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule